// File: doc/BRIEF.md
# Frame-Buffer Word to RGB Pixel Unpacker

This block turns a stream of 32-bit frame-buffer words into 24-bit RGB pixels. A 2-bit mode input picks one of four storage formats. The first is packed true color, where four pixels share three words. The second is 8-bit grey, where one byte is copied into all three channels. The third is 8-bit indexed color, where each byte looks up an entry in an external palette RAM. The fourth is 16-bit color with 5-6-5 fields, which is widened to 8 bits per channel by zero-filling the low bits. Every output pixel carries red in bits [23:16], green in [15:8] and blue in [7:0].

Words arrive on a valid/ready input and pixels leave on a valid/ready output. For indexed color the block drives a read port into a 512-entry palette RAM. That RAM returns data one cycle after a read strobe, and its 9-bit address places a bank bit above the 8-bit index. A synchronous clear empties the pipeline and returns the block to the first pixel of a group. The mode may only change while clear is asserted.

Top module: `pixel_unpacker`

## Requirements
- R1: After reset, and in the first cycle after clear is released, outValid is low. The next pixel is then built as the first pixel of a new group, starting from the next accepted word.
- R2: In mode 0 (packed true color), each three accepted words w0, w1, w2 give four pixels in this order: w0[31:8]; {w0[7:0], w1[31:16]}; {w1[15:0], w2[31:24]}; w2[23:0].
- R3: In mode 1 (grey), each word gives four pixels with its most significant byte first, bits [31:24] first and bits [7:0] last. Each pixel is {b, b, b}.
- R4: In mode 2 (indexed), each word gives four bytes with its most significant byte first. For each byte the block pulses lutRead with lutAddr[7:0] equal to that byte. The pixel is the 24-bit lutData returned in the following cycle.
- R5: lutAddr[8] equals bank whenever lutRead is high, so bank 0 reads entries 0 to 255 and bank 1 reads entries 256 to 511.
- R6: In mode 3 (5-6-5), each word gives two pixels, upper halfword first. A halfword h becomes {h[15:11], 3'b000, h[10:5], 2'b00, h[4:0], 3'b000}.
- R7: While outValid is high and outReady is low, outValid stays high and outPixel stays unchanged in the next cycle.
- R8: Under any pattern of inValid and outReady, every pixel is delivered exactly once and in stream order.
- R9: While clear is high, inReady and lutRead are low. Any partly used word, partial group or pixel in flight is discarded.
- R10: Accepted words per pixel are exactly 3 per 4 in mode 0, 1 per 4 in modes 1 and 2, and 1 per 2 in mode 3. No pixel appears beyond those the accepted words define.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| clear | input | 1 | Synchronous flush, returns to group start |
| mode | input | 2 | 0 true color, 1 grey, 2 indexed, 3 5-6-5 |
| bank | input | 1 | Palette half select for indexed mode |
| inValid | input | 1 | Input word valid |
| inReady | output | 1 | Input word accepted when high with inValid |
| inWord | input | 32 | Frame-buffer word |
| outValid | output | 1 | Output pixel valid |
| outReady | input | 1 | Downstream accepts pixel |
| outPixel | output | 24 | RGB pixel, red high |
| lutRead | output | 1 | Palette read strobe |
| lutAddr | output | 9 | Palette address {bank, index} |
| lutData | input | 24 | Palette data, valid the cycle after lutRead |

## Verification
The checker module watches several properties on every cycle. It checks that a stalled output stays stable, that clear blocks input acceptance and palette reads and empties the output, that palette reads occur only in indexed mode and carry the bank bit, that grey pixels have three equal channels, and that 5-6-5 pixels have zero padding bits. The bench alone can show that the bytes land in the right place, that the palette data is matched to the right index, and that the order of pixels across straddled words is correct. It can also show that the word-to-pixel ratio holds and that a clear in the middle of a group really discards the partial state. It does this by comparing every pixel against model functions while inValid and outReady toggle at random.

// File: rtl/pxu_pkg.sv
`timescale 1ns/1ps
package pxu_pkg;
  localparam int WORD_W  = 32;
  localparam int PIX_W   = 24;
  localparam int CH_W    = 8;
  localparam int HALF_W  = WORD_W / 2;
  localparam int LANES   = WORD_W / CH_W;
  localparam int PH_W    = $clog2(LANES);
  localparam int IDX_W   = CH_W;
  localparam int LUT_AW  = IDX_W + 1;
  localparam int R5_W    = 5;
  localparam int G6_W    = 6;

  typedef enum logic [1:0] {
    MODE_RGB24  = 2'd0,
    MODE_GRAY   = 2'd1,
    MODE_CLUT   = 2'd2,
    MODE_RGB565 = 2'd3
  } pxMode_e;

  typedef struct packed {
    logic            issue;     // a pixel enters stage 1 this cycle
    logic            takeWord;  // the input word is consumed with it
    logic [PH_W-1:0] phase;     // pixel position inside the group
    logic            move2;     // stage 1 moves to the output stage
    logic            capLut;    // stalled stage 1 captures palette data
    logic            pend1;     // stage 1 waits on palette data
  } pxCtl_t;
endpackage

// File: rtl/pxu_ctrl.sv
`timescale 1ns/1ps
module pxu_ctrl
  import pxu_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        clear,
  input  logic [1:0]  mode,
  input  logic        inValid,
  input  logic        outReady,
  output logic        inReady,
  output logic        outValid,
  output logic        lutRead,
  output pxCtl_t      ctl
);
  logic [PH_W-1:0] phase;
  logic v1, pend1, v2;
  logic needIn, lastPh, isLut, adv2, stage1Free, issue;
  pxMode_e md;

  assign md = pxMode_e'(mode);

  always_comb begin
    case (md)
      MODE_RGB24:  needIn = (phase != PH_W'(LANES - 1));
      MODE_RGB565: needIn = (phase == '0);
      default:     needIn = (phase == '0);
    endcase
    lastPh = (md == MODE_RGB565) ? (phase == PH_W'(1))
                                 : (phase == PH_W'(LANES - 1));
  end

  assign isLut      = (md == MODE_CLUT);
  assign adv2       = v1 && (!v2 || outReady);
  assign stage1Free = !v1 || adv2;
  assign issue      = !clear && stage1Free && (!needIn || inValid);
  assign inReady    = !clear && needIn && stage1Free;
  assign lutRead    = issue && isLut;
  assign outValid   = v2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase <= '0;
      v1    <= 1'b0;
      pend1 <= 1'b0;
      v2    <= 1'b0;
    end else if (clear) begin
      phase <= '0;
      v1    <= 1'b0;
      pend1 <= 1'b0;
      v2    <= 1'b0;
    end else begin
      if (issue) phase <= lastPh ? '0 : phase + PH_W'(1);
      if (issue) begin
        v1    <= 1'b1;
        pend1 <= isLut;
      end else if (adv2) begin
        v1    <= 1'b0;
        pend1 <= 1'b0;
      end else if (pend1) begin
        pend1 <= 1'b0;
      end
      if (adv2)          v2 <= 1'b1;
      else if (outReady) v2 <= 1'b0;
    end
  end

  always_comb begin
    ctl.issue    = issue;
    ctl.takeWord = issue && needIn;
    ctl.phase    = phase;
    ctl.move2    = adv2 && !clear;
    ctl.capLut   = pend1 && !adv2;
    ctl.pend1    = pend1;
  end
endmodule

// File: rtl/pxu_dpath.sv
`timescale 1ns/1ps
module pxu_dpath
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  pxCtl_t            ctl,
  input  logic [1:0]        mode,
  input  logic              bank,
  input  logic [WORD_W-1:0] inWord,
  input  logic [PIX_W-1:0]  lutData,
  output logic [PIX_W-1:0]  outPixel,
  output logic [LUT_AW-1:0] lutAddr
);
  logic [WORD_W-1:0] prevWord, src;
  logic [CH_W-1:0]   lane [LANES];
  logic [CH_W-1:0]   byteSel;
  logic [HALF_W-1:0] halfSel;
  logic [PIX_W-1:0]  pix24, pixGray, pix565, direct, pix1, pix2;
  pxMode_e md;

  assign md  = pxMode_e'(mode);
  assign src = ctl.takeWord ? inWord : prevWord;

  for (genvar b = 0; b < LANES; b++) begin : gLane
    assign lane[b] = src[WORD_W-1-CH_W*b -: CH_W];
  end

  assign byteSel = lane[ctl.phase];
  assign halfSel = ctl.phase[0] ? src[HALF_W-1:0] : src[WORD_W-1:HALF_W];

  always_comb begin
    case (ctl.phase)
      2'd0:    pix24 = inWord[WORD_W-1:WORD_W-PIX_W];
      2'd1:    pix24 = {prevWord[CH_W-1:0], inWord[WORD_W-1:HALF_W]};
      2'd2:    pix24 = {prevWord[HALF_W-1:0], inWord[WORD_W-1:WORD_W-CH_W]};
      default: pix24 = prevWord[PIX_W-1:0];
    endcase
  end

  assign pixGray = {byteSel, byteSel, byteSel};
  assign pix565  = {halfSel[HALF_W-1 -: R5_W], {(CH_W-R5_W){1'b0}},
                    halfSel[R5_W+G6_W-1 -: G6_W], {(CH_W-G6_W){1'b0}},
                    halfSel[R5_W-1:0], {(CH_W-R5_W){1'b0}}};

  always_comb begin
    case (md)
      MODE_RGB24:  direct = pix24;
      MODE_GRAY:   direct = pixGray;
      MODE_RGB565: direct = pix565;
      default:     direct = '0;
    endcase
  end

  assign lutAddr  = {bank, byteSel};
  assign outPixel = pix2;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevWord <= '0;
      pix1     <= '0;
      pix2     <= '0;
    end else begin
      if (ctl.takeWord) prevWord <= inWord;
      if (ctl.issue)       pix1 <= direct;
      else if (ctl.capLut) pix1 <= lutData;
      if (ctl.move2) pix2 <= ctl.pend1 ? lutData : pix1;
    end
  end
endmodule

// File: rtl/pixel_unpacker.sv
`timescale 1ns/1ps
module pixel_unpacker
  import pxu_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              clear,
  input  logic [1:0]        mode,
  input  logic              bank,
  input  logic              inValid,
  output logic              inReady,
  input  logic [WORD_W-1:0] inWord,
  output logic              outValid,
  input  logic              outReady,
  output logic [PIX_W-1:0]  outPixel,
  output logic              lutRead,
  output logic [LUT_AW-1:0] lutAddr,
  input  logic [PIX_W-1:0]  lutData
);
  pxCtl_t ctl;

  pxu_ctrl uCtrl (
    .clk(clk), .rstN(rstN), .clear(clear), .mode(mode),
    .inValid(inValid), .outReady(outReady), .inReady(inReady),
    .outValid(outValid), .lutRead(lutRead), .ctl(ctl)
  );

  pxu_dpath uDpath (
    .clk(clk), .rstN(rstN), .ctl(ctl), .mode(mode), .bank(bank),
    .inWord(inWord), .lutData(lutData), .outPixel(outPixel),
    .lutAddr(lutAddr)
  );
endmodule

// File: rtl/pxu_chk.sv
`timescale 1ns/1ps
module pxu_chk
  import pxu_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              clear,
  input logic [1:0]        mode,
  input logic              bank,
  input logic              inReady,
  input logic              outValid,
  input logic              outReady,
  input logic [PIX_W-1:0]  outPixel,
  input logic              lutRead,
  input logic [LUT_AW-1:0] lutAddr
);
  // R7
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady && !clear |=> outValid && $stable(outPixel));

  // R9
  clear_block_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |-> !inReady && !lutRead);

  // R1
  clear_flush_chk: assert property (@(posedge clk) disable iff (!rstN)
    clear |=> !outValid);

  // R4
  lut_mode_chk: assert property (@(posedge clk) disable iff (!rstN)
    lutRead |-> mode == 2'd2);

  // R5
  lut_bank_chk: assert property (@(posedge clk) disable iff (!rstN)
    lutRead |-> lutAddr[LUT_AW-1] == bank);

  // R3
  gray_equal_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !clear && mode == 2'd1 |->
      outPixel[23:16] == outPixel[15:8] && outPixel[15:8] == outPixel[7:0]);

  // R6
  pad_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !clear && mode == 2'd3 |->
      outPixel[18:16] == 3'b0 && outPixel[9:8] == 2'b0 && outPixel[2:0] == 3'b0);
endmodule

bind pixel_unpacker pxu_chk uChk (
  .clk(clk), .rstN(rstN), .clear(clear), .mode(mode), .bank(bank),
  .inReady(inReady), .outValid(outValid), .outReady(outReady),
  .outPixel(outPixel), .lutRead(lutRead), .lutAddr(lutAddr)
);

// File: tb/pixel_unpacker_test.sv
`timescale 1ns/1ps
module pixel_unpacker_test;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        clear = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        bank = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [31:0] inWord = '0;
  logic        outValid;
  logic        outReady = 1'b0;
  logic [23:0] outPixel;
  logic        lutRead;
  logic [8:0]  lutAddr;
  logic [23:0] lutData = '0;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  logic [31:0] words [96];

  always #2 clk = ~clk;

  pixel_unpacker uut (
    .clk(clk), .rstN(rstN), .clear(clear), .mode(mode), .bank(bank),
    .inValid(inValid), .inReady(inReady), .inWord(inWord),
    .outValid(outValid), .outReady(outReady), .outPixel(outPixel),
    .lutRead(lutRead), .lutAddr(lutAddr), .lutData(lutData)
  );

  function automatic logic [23:0] lutFn(input logic [8:0] a);
    logic [7:0] i;
    i = a[7:0];
    return {i ^ (a[8] ? 8'h5A : 8'hC3), i + 8'd17, ~i};
  endfunction

  // palette RAM model: one cycle read latency
  always @(posedge clk) if (lutRead) lutData <= lutFn(lutAddr);

  function automatic logic [23:0] expPix(input int md, input logic bk, input int k);
    logic [31:0] w0, w1, w2, w;
    logic [7:0]  b;
    logic [15:0] h;
    case (md)
      0: begin
        w0 = words[3*(k/4)]; w1 = words[3*(k/4)+1]; w2 = words[3*(k/4)+2];
        case (k % 4)
          0: return w0[31:8];
          1: return {w0[7:0], w1[31:16]};
          2: return {w1[15:0], w2[31:24]};
          default: return w2[23:0];
        endcase
      end
      1, 2: begin
        w = words[k/4];
        b = w[31 - 8*(k%4) -: 8];
        if (md == 1) return {b, b, b};
        return lutFn({bk, b});
      end
      default: begin
        w = words[k/2];
        h = (k % 2 == 0) ? w[31:16] : w[15:0];
        return {h[15:11], 3'b0, h[10:5], 2'b0, h[4:0], 3'b0};
      end
    endcase
  endfunction

  task automatic checkVal(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic fillWords(input int kind);
    for (int i = 0; i < 96; i++) words[i] = $urandom;
    if (kind == 1) begin
      words[0] = 32'hFFFF_FFFF; words[1] = 32'h0000_0000; words[2] = 32'h0102_0304;
    end
  endtask

  task automatic runStream(input int md, input logic bk, input int n,
                           input int vPct, input int rPct, input string tag);
    int nPix, wi, pi, cyc;
    logic inHs, outHs, stalled;
    logic [23:0] heldPix;
    @(negedge clk);
    clear = 1'b1; mode = md[1:0]; bank = bk; inValid = 1'b1; outReady = 1'b0;
    #1 checkVal("R9 inReady during clear", {31'b0, inReady}, 32'd0);
    @(negedge clk);
    clear = 1'b0; inValid = 1'b0;
    #1 checkVal("R1 outValid after clear", {31'b0, outValid}, 32'd0);
    nPix = (md == 0) ? n * 4 / 3 : (md == 3) ? n * 2 : n * 4;
    wi = 0; pi = 0; cyc = 0; stalled = 1'b0; heldPix = '0;
    while (pi < nPix && cyc < 20000) begin
      @(negedge clk);
      if (wi < n) begin
        inValid = (($urandom % 100) < vPct);
        inWord  = words[wi];
      end else inValid = 1'b0;
      outReady = (($urandom % 100) < rPct);
      #1;
      if (stalled) begin
        checkVal("R7 held valid", {31'b0, outValid}, 32'd1);
        checkVal("R7 held pixel", {8'b0, outPixel}, {8'b0, heldPix});
      end
      inHs  = inValid && inReady;
      outHs = outValid && outReady;
      stalled = outValid && !outReady;
      heldPix = outPixel;
      if (outHs) begin
        checkVal(tag, {8'b0, outPixel}, {8'b0, expPix(md, bk, pi)});
        pi++;
      end
      if (inHs) wi++;
      cyc++;
    end
    checkVal("R8 pixel count", pi, nPix);
    checkVal("R10 words consumed", wi, n);
    @(negedge clk);
    inValid = 1'b0; outReady = 1'b1;
    repeat (6) @(negedge clk);
    #1 checkVal("R10 no surplus pixel", {31'b0, outValid}, 32'd0);
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++;
      $display("FAIL watchdog actual %0d expected below 150000", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    #1 checkVal("R1 reset outValid", {31'b0, outValid}, 32'd0);
    checkVal("R1 reset lutRead", {31'b0, lutRead}, 32'd0);
    rstN = 1'b1;

    // R2 packed true color, directed then random
    fillWords(1);
    runStream(0, 1'b0, 12, 100, 100, "R2 24-bit pixel");
    fillWords(0);
    runStream(0, 1'b0, 96, 60, 50, "R2 24-bit pixel");

    // R3 grey
    fillWords(1);
    runStream(1, 1'b0, 40, 70, 40, "R3 grey pixel");

    // R5 bank bit seen on the address at issue
    @(negedge clk);
    clear = 1'b1; mode = 2'd2; bank = 1'b1; inValid = 1'b0; outReady = 1'b0;
    @(negedge clk);
    clear = 1'b0; inValid = 1'b1; inWord = 32'hAB00_0000;
    #1 checkVal("R5 read address", {22'b0, lutRead, lutAddr}, {22'b0, 1'b1, 1'b1, 8'hAB});

    // R4 R5 indexed colour, both banks
    fillWords(1);
    runStream(2, 1'b0, 30, 80, 60, "R4 indexed bank0");
    fillWords(0);
    runStream(2, 1'b1, 30, 50, 30, "R4 R5 indexed bank1");

    // R6 5-6-5 colour
    fillWords(1);
    runStream(3, 1'b0, 48, 65, 45, "R6 565 pixel");

    // R9 clear mid-group: two words of a group consumed, pipeline full
    @(negedge clk);
    clear = 1'b1; mode = 2'd0; @(negedge clk); clear = 1'b0;
    inValid = 1'b1; inWord = 32'hDEAD_BEEF; outReady = 1'b0;
    @(negedge clk); inWord = 32'h1234_5678;
    @(negedge clk); inValid = 1'b0;
    fillWords(0);
    runStream(0, 1'b0, 24, 75, 35, "R9 R2 after mid-group clear");
    runStream(3, 1'b1, 20, 40, 90, "R9 R6 after mode change");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule